// File: doc/BRIEF.md
# Host-Written Word FIFO with Memory-Mapped Status

This block is a single-clock word queue that links a host processor to fabric logic. The host reaches it through a small memory-mapped slave. A write to the data window puts one word at the tail of the queue. Two status words give the host the current number of stored words and a flag word that shows whether the queue is full or empty. The host uses these to decide whether a write will be accepted.

Fabric logic drains the queue through a streaming read port. Each cycle in which its read strobe is high takes one word from the head. That word appears on the fabric data bus two clock cycles after the strobe, and a valid output marks it. The block applies no backpressure in either direction. A host write to a full queue is dropped. A fabric read of an empty queue changes nothing.

Host bus address map (two-bit word address): 0 is the data window, 1 is reserved, 2 is the fill level and 3 is the flag word. Host reads return data one cycle after the read strobe. The data window is write-only and reads as zero.

Top module: `mmFifo`

## Requirements
- R1: After reset the fill level reads 0, the flag word reads 2 (empty set, full clear) and fabRdValid is low.
- R2: A host write to address 0 appends busWrData to the queue and raises the fill level, read at address 2, by one. Every host read returns its data on busRdData in the cycle after busRdEn.
- R3: The flag word at address 3 holds full in bit 0 and empty in bit 1, and all other bits read as zero. Reads of addresses 0 and 1 return zero.
- R4: Words reach the fabric port in the order the host wrote them.
- R5: When fabRdEn is high and the queue is not empty, the head word appears on fabRdData with fabRdValid high two clock edges later, and not one edge later.
- R6: Each cycle with fabRdEn high removes one word. Holding the strobe for two cycles delivers two consecutive words on consecutive cycles.
- R7: A host write to address 0 while the queue holds DEPTH words is discarded: the fill level stays at DEPTH and the stored words are read out unchanged.
- R8: A fabric read of an empty queue moves no pointer, leaves fabRdValid low two cycles later, and leaves fabRdData at its previous value.
- R9: A push and a pop in the same cycle leave the fill level unchanged, and the popped word is the old head.
- R10: A host write to addresses 1, 2 or 3 does not change the fill level or the queue contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busAddr | input | 2 | Host word address |
| busWrData | input | DATA_W | Host write data |
| busRdData | output | DATA_W | Host read data, one cycle after busRdEn |
| fabRdEn | input | 1 | Fabric pop strobe |
| fabRdData | output | DATA_W | Fabric word, two cycles after the strobe |
| fabRdValid | output | 1 | Marks a delivered fabric word |

## Verification
A short mixed sequence interleaves pushes, status reads, pops and a write to a status address. It separates correct ordering and fill counting from a design that counts writes at any address. A fill to exactly DEPTH followed by one extra write, then a full drain, shows whether an overflow write corrupts the stored words or the count. A held two-cycle strobe, a pop of an empty queue and a same-cycle push and pop each test the pop-per-cycle rule, the hold-last-value rule and the balanced counter update. A check one cycle early on the fabric valid output tells the two-stage latency apart from a one-stage latency.

// File: rtl/mmFifoPkg.sv
package mmFifoPkg;
  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_RSVD  = 2'd1;
  localparam logic [1:0] ADDR_LEVEL = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;

  localparam int FLAG_FULL_BIT  = 0;
  localparam int FLAG_EMPTY_BIT = 1;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobes_t;
endpackage

// File: rtl/mmFifoCtrl.sv
module mmFifoCtrl
  import mmFifoPkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [1:0]         busAddr,
  input  logic               fabRdEn,
  output fifoStrobes_t       strobes,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [CNT_W-1:0]   fillCount,
  output logic               isFull,
  output logic               isEmpty
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  assign isFull  = (fillCount == FULL_CNT);
  assign isEmpty = (fillCount == '0);

  always_comb begin
    strobes.push = busWrEn && (busAddr == ADDR_DATA) && !isFull;
    strobes.pop  = fabRdEn && !isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)  rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      unique case ({strobes.push, strobes.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end
endmodule

// File: rtl/mmFifoDatapath.sv
module mmFifoDatapath
  import mmFifoPkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrobes_t       strobes,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [CNT_W-1:0]   fillCount,
  input  logic               isFull,
  input  logic               isEmpty,
  input  logic               busRdEn,
  input  logic [1:0]         busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [DATA_W-1:0]  fabRdData,
  output logic               fabRdValid
);
  logic [DATA_W-1:0] storage [DEPTH];
  logic [DATA_W-1:0] headStage;
  logic              headValid;
  logic [DATA_W-1:0] flagsWord;
  logic [DATA_W-1:0] rdMux;

  // storage array and first read stage, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (strobes.push) storage[wrPtr] <= busWrData;
    if (strobes.pop)  headStage      <= storage[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headValid  <= 1'b0;
      fabRdValid <= 1'b0;
      fabRdData  <= '0;
    end else begin
      headValid  <= strobes.pop;
      fabRdValid <= headValid;
      if (headValid) fabRdData <= headStage;
    end
  end

  always_comb begin
    flagsWord                 = '0;
    flagsWord[FLAG_FULL_BIT]  = isFull;
    flagsWord[FLAG_EMPTY_BIT] = isEmpty;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_LEVEL: rdMux = DATA_W'(fillCount);
      ADDR_FLAGS: rdMux = flagsWord;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busRdData <= '0;
    else if (busRdEn) busRdData <= rdMux;
  end
endmodule

// File: rtl/mmFifo.sv
module mmFifo
  import mmFifoPkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              fabRdEn,
  output logic [DATA_W-1:0] fabRdData,
  output logic              fabRdValid
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobes_t     ctrlStrobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] fillCount;
  logic             isFull;
  logic             isEmpty;

  mmFifoCtrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .fabRdEn(fabRdEn), .strobes(ctrlStrobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .fillCount(fillCount), .isFull(isFull), .isEmpty(isEmpty)
  );

  mmFifoDatapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(ctrlStrobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .fillCount(fillCount), .isFull(isFull), .isEmpty(isEmpty),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .fabRdData(fabRdData), .fabRdValid(fabRdValid)
  );
endmodule

// File: rtl/mmFifoChecker.sv
module mmFifoChecker #(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic [1:0]       busAddr,
  input logic             fabRdEn,
  input logic             fabRdValid,
  input logic [CNT_W-1:0] fillCount,
  input logic             isFull,
  input logic             isEmpty,
  input logic             push,
  input logic             pop
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH)); // R7

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0 && isFull && !fabRdEn) |=> $stable(fillCount)); // R7

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty)); // R3

  AST_POP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (fabRdEn && !isEmpty) |-> ##2 fabRdValid); // R5

  AST_EMPTY_POP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (fabRdEn && isEmpty) |-> ##2 !fabRdValid); // R8

  AST_BALANCED_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop) |=> $stable(fillCount)); // R9

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != 2'd0 && !fabRdEn) |=> $stable(fillCount)); // R10
endmodule

bind mmFifo mmFifoChecker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .fabRdEn(fabRdEn), .fabRdValid(fabRdValid), .fillCount(fillCount),
  .isFull(isFull), .isEmpty(isEmpty),
  .push(ctrlStrobes.push), .pop(ctrlStrobes.pop)
);

// File: tb/mmFifo_bench.sv
module mmFifo_bench;
  localparam int DEPTH  = 256;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [1:0]        busAddr = 2'd0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              fabRdEn = 1'b0;
  logic [DATA_W-1:0] fabRdData;
  logic              fabRdValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mmFifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mmFifo (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .fabRdEn(fabRdEn), .fabRdData(fabRdData), .fabRdValid(fabRdValid)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 host read, 2 fabric pop
    logic [1:0]  addr;
    logic [31:0] val;
    logic [3:0]  tag;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 32'h1111_1111, 4'd2},
    '{2'd0, 2'd0, 32'h2222_2222, 4'd2},
    '{2'd0, 2'd0, 32'hA5A5_A5A5, 4'd2},
    '{2'd1, 2'd2, 32'd3,         4'd2},
    '{2'd1, 2'd3, 32'd0,         4'd3},
    '{2'd2, 2'd0, 32'h1111_1111, 4'd4},
    '{2'd1, 2'd2, 32'd2,         4'd2},
    '{2'd0, 2'd2, 32'h0000_DEAD, 4'd10},
    '{2'd1, 2'd2, 32'd2,         4'd10},
    '{2'd2, 2'd0, 32'h2222_2222, 4'd4},
    '{2'd2, 2'd0, 32'hA5A5_A5A5, 4'd4},
    '{2'd1, 2'd3, 32'd2,         4'd3},
    '{2'd1, 2'd1, 32'd0,         4'd3}
  };

  function automatic string reqName(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic fabPop(output logic [31:0] d, output logic v, output logic early);
    fabRdEn = 1'b1;
    @(negedge clk);
    fabRdEn = 1'b0;
    early = fabRdValid;
    @(negedge clk);
    d = fabRdData;
    v = fabRdValid;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic v, e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 fabRdValid", {31'd0, fabRdValid}, 32'd0);
    hostRead(2'd2, d); chk("R1 level", d, 32'd0);
    hostRead(2'd3, d); chk("R1 flags", d, 32'd2);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        2'd0: hostWrite(VECS[i].addr, VECS[i].val);
        2'd1: begin
          hostRead(VECS[i].addr, d);
          chk(reqName(VECS[i].tag), d, VECS[i].val);
        end
        default: begin
          fabPop(d, v, e);
          chk("R5 valid", {31'd0, v}, 32'd1);
          chk("R5 early valid", {31'd0, e}, 32'd0);
          chk(reqName(VECS[i].tag), d, VECS[i].val);
        end
      endcase
    end

    // R6 strobe held two cycles pops two words
    hostWrite(2'd0, 32'hCAFE_0001);
    hostWrite(2'd0, 32'hCAFE_0002);
    fabRdEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    fabRdEn = 1'b0;
    chk("R6 first word", fabRdData, 32'hCAFE_0001);
    chk("R6 first valid", {31'd0, fabRdValid}, 32'd1);
    @(negedge clk);
    chk("R6 second word", fabRdData, 32'hCAFE_0002);
    chk("R6 second valid", {31'd0, fabRdValid}, 32'd1);
    hostRead(2'd2, d); chk("R6 level", d, 32'd0);

    // R7 fill to full, extra write dropped
    for (int i = 0; i < DEPTH; i++) hostWrite(2'd0, 32'h100 + i);
    hostRead(2'd3, d); chk("R3 full flag", d, 32'd1);
    hostWrite(2'd0, 32'h0000_0BAD);
    hostRead(2'd2, d); chk("R7 level at full", d, DEPTH);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        fabPop(d, v, e);
        if (d !== 32'h100 + i || v !== 1'b1) bad++;
      end
      chk("R7 contents intact", bad, 32'd0);
    end

    // R8 pop of empty queue
    fabPop(d, v, e);
    chk("R8 no valid", {31'd0, v}, 32'd0);
    chk("R8 holds last", d, 32'h100 + DEPTH - 1);
    hostRead(2'd2, d); chk("R8 level", d, 32'd0);

    // R9 simultaneous push and pop
    hostWrite(2'd0, 32'h5555_0001);
    busWrEn = 1'b1; busAddr = 2'd0; busWrData = 32'h5555_0002; fabRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; fabRdEn = 1'b0;
    @(negedge clk);
    chk("R9 old head", fabRdData, 32'h5555_0001);
    hostRead(2'd2, d); chk("R9 level", d, 32'd1);
    fabPop(d, v, e); chk("R9 new word", d, 32'h5555_0002);

    finished = 1'b1;
    summary();
  end
endmodule